// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block chooses where each of the two register operands of an instruction comes from while that instruction sits in the decode stage of a five-stage in-order integer pipeline. The choice is made before the operands are captured into the registers that feed the execute stage. Three later pipeline stages may hold a newer value for the same architectural register: execute, memory and write-back. Each of those stages carries its own destination register number and write enable down the pipe with its instruction. The unit compares these against the two source register numbers of the decoding instruction.

For each operand the unit produces a 2-bit select and the selected 32-bit value. When several stages target the same register, the youngest producer wins. Register zero is hard-wired and is never forwarded. The logic holds no state, and its outputs follow its inputs within the same cycle.

Top module: `dec_fwd_unit`

## Requirements
- R1: The select encoding is 0 = register-file value, 1 = execute-stage result, 2 = memory-stage result, 3 = write-back data. Each output operand equals the source named by its select.
- R2: When the execute stage matches a source, that operand selects code 1, whatever the memory and write-back stages hold.
- R3: When the execute stage does not match but the memory stage does, the operand selects code 2, even if the write-back stage also matches.
- R4: A stage whose write enable is low never supplies an operand, even when its destination number equals the source number.
- R5: A stage supplies an operand only when its destination number equals that operand's source number.
- R6: A source register number of zero always selects code 0 and passes the register-file value, even when a downstream stage writes register zero.
- R7: The first and second operands are resolved independently: each one's select depends only on its own source number and the shared stage state.
- R8: The outputs are combinational. They reflect new inputs in the same cycle, with no clock edge in between.
- R9: When no stage matches an operand, that operand selects code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the decoding instruction |
| src_b_idx | input | 5 | Second source register number of the decoding instruction |
| rf_a_data | input | 32 | Register-file read value for the first operand |
| rf_b_data | input | 32 | Register-file read value for the second operand |
| ex_dst | input | 5 | Destination register number of the execute-stage instruction |
| ex_we | input | 1 | Register-write enable of the execute-stage instruction |
| ex_result | input | 32 | Execute-stage ALU result |
| mem_dst | input | 5 | Destination register number of the memory-stage instruction |
| mem_we | input | 1 | Register-write enable of the memory-stage instruction |
| mem_result | input | 32 | Memory-stage result |
| wb_dst | input | 5 | Destination register number of the write-back-stage instruction |
| wb_we | input | 1 | Register-write enable of the write-back-stage instruction |
| wb_data | input | 32 | Write-back data |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| opnd_a | output | 32 | Forwarded first operand |
| opnd_b | output | 32 | Forwarded second operand |

## Verification
The hardest case to reach is three downstream stages that all aim at one register while only some of their write enables are set. That same case also arises with register zero as the target. In a real instruction stream these overlaps are rare. The stimulus table therefore sets destination numbers and enables directly, stage by stage. It puts several stages on the same register and turns enables off one at a time, so that each step down the priority chain is exposed. Both operands point at the same or at different stages within one vector, which shows that they are resolved independently.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int unsigned NUM_FWD_STG = 3;
  localparam int unsigned SEL_W       = $clog2(NUM_FWD_STG + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2,
    SEL_WB  = 2'd3
  } fwd_sel_e;

  // A stage produces the operand when it writes, targets the same
  // register, and that register is not the hard-wired zero.
  function automatic logic stage_hits(input logic [7:0] src,
                                      input logic [7:0] dst,
                                      input logic       we);
    return we && (src == dst) && (src != '0);
  endfunction

  // Youngest-first priority: bit 0 is execute, then memory, then write-back.
  function automatic fwd_sel_e pick_source(input logic [NUM_FWD_STG-1:0] hits);
    fwd_sel_e s;
    s = SEL_RF;
    for (int i = NUM_FWD_STG - 1; i >= 0; i--) begin
      if (hits[i]) s = fwd_sel_e'(i + 1);
    end
    return s;
  endfunction

endpackage

// File: rtl/fwd_stage_cmp.sv
module fwd_stage_cmp #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [REG_AW-1:0] dst_idx,
  input  logic              dst_we,
  output logic              hit
);
  import fwd_pkg::*;

  always_comb begin
    hit = stage_hits(8'(src_idx), 8'(dst_idx), dst_we);
  end

endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [fwd_pkg::NUM_FWD_STG-1:0] hits,
  input  logic [DATA_W-1:0]               rf_data,
  input  logic [DATA_W-1:0]               stg_data [fwd_pkg::NUM_FWD_STG],
  output logic [fwd_pkg::SEL_W-1:0]       sel,
  output logic [DATA_W-1:0]               opnd
);
  import fwd_pkg::*;

  localparam int unsigned NCAND = NUM_FWD_STG + 1;

  logic [DATA_W-1:0] cand [NCAND];
  fwd_sel_e          pick;

  always_comb begin
    cand[0] = rf_data;
    for (int i = 0; i < NUM_FWD_STG; i++) cand[i+1] = stg_data[i];
  end

  always_comb begin
    pick = pick_source(hits);
    sel  = pick;
    opnd = cand[pick];
  end

endmodule

// File: rtl/dec_fwd_unit.sv
module dec_fwd_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0]          src_a_idx,
  input  logic [REG_AW-1:0]          src_b_idx,
  input  logic [DATA_W-1:0]          rf_a_data,
  input  logic [DATA_W-1:0]          rf_b_data,
  input  logic [REG_AW-1:0]          ex_dst,
  input  logic                       ex_we,
  input  logic [DATA_W-1:0]          ex_result,
  input  logic [REG_AW-1:0]          mem_dst,
  input  logic                       mem_we,
  input  logic [DATA_W-1:0]          mem_result,
  input  logic [REG_AW-1:0]          wb_dst,
  input  logic                       wb_we,
  input  logic [DATA_W-1:0]          wb_data,
  output logic [fwd_pkg::SEL_W-1:0]  sel_a,
  output logic [fwd_pkg::SEL_W-1:0]  sel_b,
  output logic [DATA_W-1:0]          opnd_a,
  output logic [DATA_W-1:0]          opnd_b
);
  import fwd_pkg::*;

  localparam int unsigned NOPND = 2;

  logic [REG_AW-1:0] src_idx [NOPND];
  logic [DATA_W-1:0] rf_data [NOPND];
  logic [REG_AW-1:0] stg_dst [NUM_FWD_STG];
  logic              stg_we  [NUM_FWD_STG];
  logic [DATA_W-1:0] stg_val [NUM_FWD_STG];
  logic [NUM_FWD_STG-1:0] hit [NOPND];
  logic [SEL_W-1:0]  sel_o  [NOPND];
  logic [DATA_W-1:0] opnd_o [NOPND];

  // Named match events, visible to the checker.
  logic [NUM_FWD_STG-1:0] a_hit;
  logic [NUM_FWD_STG-1:0] b_hit;

  always_comb begin
    src_idx[0] = src_a_idx;
    src_idx[1] = src_b_idx;
    rf_data[0] = rf_a_data;
    rf_data[1] = rf_b_data;
    stg_dst[0] = ex_dst;
    stg_dst[1] = mem_dst;
    stg_dst[2] = wb_dst;
    stg_we[0]  = ex_we;
    stg_we[1]  = mem_we;
    stg_we[2]  = wb_we;
    stg_val[0] = ex_result;
    stg_val[1] = mem_result;
    stg_val[2] = wb_data;
  end

  for (genvar op = 0; op < NOPND; op++) begin : g_opnd
    for (genvar st = 0; st < NUM_FWD_STG; st++) begin : g_stg
      fwd_stage_cmp #(.REG_AW(REG_AW)) cmp_i (
        .src_idx (src_idx[op]),
        .dst_idx (stg_dst[st]),
        .dst_we  (stg_we[st]),
        .hit     (hit[op][st])
      );
    end
    fwd_opnd_mux #(.DATA_W(DATA_W)) mux_i (
      .hits     (hit[op]),
      .rf_data  (rf_data[op]),
      .stg_data (stg_val),
      .sel      (sel_o[op]),
      .opnd     (opnd_o[op])
    );
  end

  always_comb begin
    a_hit  = hit[0];
    b_hit  = hit[1];
    sel_a  = sel_o[0];
    sel_b  = sel_o[1];
    opnd_a = opnd_o[0];
    opnd_b = opnd_o[1];
  end

endmodule

// File: rtl/dec_fwd_unit_chk.sv
module dec_fwd_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] src_a_idx,
  input logic [REG_AW-1:0] src_b_idx,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_we,
  input logic [DATA_W-1:0] ex_result,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_result,
  input logic [REG_AW-1:0] wb_dst,
  input logic              wb_we,
  input logic [DATA_W-1:0] wb_data,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [2:0]        a_hit,
  input logic [2:0]        b_hit
);

  always_comb begin
    // R1
    a_ex_val_chk: assert (sel_a != 2'd1 || opnd_a == ex_result);
    // R1
    b_wb_val_chk: assert (sel_b != 2'd3 || opnd_b == wb_data);
    // R6
    a_zero_chk: assert (src_a_idx != '0 || (sel_a == 2'd0 && opnd_a == rf_a_data));
    // R6
    b_zero_chk: assert (src_b_idx != '0 || (sel_b == 2'd0 && opnd_b == rf_b_data));
    // R4
    a_we_chk: assert ((sel_a != 2'd1 || ex_we) && (sel_a != 2'd2 || mem_we) && (sel_a != 2'd3 || wb_we));
    // R5
    b_dst_chk: assert ((sel_b != 2'd1 || ex_dst == src_b_idx) && (sel_b != 2'd2 || mem_dst == src_b_idx)
                       && (sel_b != 2'd3 || wb_dst == src_b_idx));
    // R2
    a_ex_prio_chk: assert (!a_hit[0] || sel_a == 2'd1);
    // R3
    b_mem_prio_chk: assert (!(b_hit[1] && !b_hit[0]) || sel_b == 2'd2);
    // R9
    a_default_chk: assert (a_hit != 3'b000 || sel_a == 2'd0);
  end

endmodule

bind dec_fwd_unit dec_fwd_unit_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) chk_i (
  .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
  .rf_a_data (rf_a_data), .rf_b_data (rf_b_data),
  .ex_dst (ex_dst), .ex_we (ex_we), .ex_result (ex_result),
  .mem_dst (mem_dst), .mem_we (mem_we), .mem_result (mem_result),
  .wb_dst (wb_dst), .wb_we (wb_we), .wb_data (wb_data),
  .sel_a (sel_a), .sel_b (sel_b), .opnd_a (opnd_a), .opnd_b (opnd_b),
  .a_hit (a_hit), .b_hit (b_hit)
);

// File: tb/dec_fwd_unit_tb_top.sv
module dec_fwd_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  src_a_idx, src_b_idx, ex_dst, mem_dst, wb_dst;
  logic        ex_we, mem_we, wb_we;
  logic [31:0] rf_a_data, rf_b_data, ex_result, mem_result, wb_data;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_cmp = 0;
  int n_bad = 0;

  dec_fwd_unit dut_i (
    .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
    .rf_a_data (rf_a_data), .rf_b_data (rf_b_data),
    .ex_dst (ex_dst), .ex_we (ex_we), .ex_result (ex_result),
    .mem_dst (mem_dst), .mem_we (mem_we), .mem_result (mem_result),
    .wb_dst (wb_dst), .wb_we (wb_we), .wb_data (wb_data),
    .sel_a (sel_a), .sel_b (sel_b), .opnd_a (opnd_a), .opnd_b (opnd_b)
  );

  // Vector: {src_a, src_b, ex_dst, ex_we, mem_dst, mem_we, wb_dst, wb_we, exp_a, exp_b}
  localparam int NVEC = 13;
  localparam logic [31:0] VEC [NVEC] = '{
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 2'd0, 2'd0}, // R9
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 2'd1, 2'd0}, // R1
    {5'd3,  5'd4,  5'd4,  1'b1, 5'd3,  1'b1, 5'd0,  1'b0, 2'd2, 2'd1}, // R1 R7
    {5'd5,  5'd6,  5'd0,  1'b0, 5'd0,  1'b0, 5'd5,  1'b1, 2'd3, 2'd0}, // R1
    {5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  1'b1, 2'd1, 2'd1}, // R2
    {5'd8,  5'd8,  5'd9,  1'b1, 5'd8,  1'b1, 5'd8,  1'b1, 2'd2, 2'd2}, // R3
    {5'd8,  5'd9,  5'd8,  1'b0, 5'd8,  1'b1, 5'd9,  1'b1, 2'd2, 2'd3}, // R4
    {5'd10, 5'd11, 5'd10, 1'b0, 5'd10, 1'b0, 5'd10, 1'b0, 2'd0, 2'd0}, // R4
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0}, // R6
    {5'd0,  5'd12, 5'd0,  1'b1, 5'd12, 1'b1, 5'd0,  1'b0, 2'd0, 2'd2}, // R6 R7
    {5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 2'd2, 2'd1}, // R7
    {5'd13, 5'd14, 5'd12, 1'b1, 5'd15, 1'b1, 5'd16, 1'b1, 2'd0, 2'd0}, // R5
    {5'd31, 5'd31, 5'd0,  1'b0, 5'd0,  1'b0, 5'd31, 1'b1, 2'd3, 2'd3}  // R1
  };

  function automatic logic [31:0] value_for(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'd1:    return ex_result;
      2'd2:    return mem_result;
      2'd3:    return wb_data;
      default: return rf;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb);
    logic [31:0] va, vb;
    va = value_for(ea, rf_a_data);
    vb = value_for(eb, rf_b_data);
    n_cmp++;
    if (sel_a !== ea || opnd_a !== va) begin
      n_bad++;
      $display("FAIL %s operand A: sel=%0d opnd=%h expected sel=%0d opnd=%h", req, sel_a, opnd_a, ea, va);
    end
    n_cmp++;
    if (sel_b !== eb || opnd_b !== vb) begin
      n_bad++;
      $display("FAIL %s operand B: sel=%0d opnd=%h expected sel=%0d opnd=%h", req, sel_b, opnd_b, eb, vb);
    end
  endtask

  task automatic apply(input logic [31:0] v);
    {src_a_idx, src_b_idx, ex_dst, ex_we, mem_dst, mem_we, wb_dst, wb_we} = v[31:4];
  endtask

  task automatic set_data(input logic [31:0] seed);
    rf_a_data  = 32'hA0A0_0000 ^ seed;
    rf_b_data  = 32'hB0B0_0000 ^ seed;
    ex_result  = 32'h1111_0001 ^ seed;
    mem_result = 32'h2222_0002 ^ seed;
    wb_data    = 32'h3333_0003 ^ seed;
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    apply('0);
    set_data(32'h0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", 2'd0, 2'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      apply(VEC[i]);
      set_data(32'h0000_0100 * i);
      @(negedge clk);
      check($sformatf("vector %0d (R1-family)", i), VEC[i][3:2], VEC[i][1:0]);
    end

    // R8: change inputs between edges and look 1 ns later, no clock edge in between.
    @(negedge clk);
    apply({5'd20, 5'd21, 5'd21, 1'b1, 5'd20, 1'b1, 5'd0, 1'b0, 4'h0});
    #1;
    check("R8 same-cycle", 2'd2, 2'd1);
    apply({5'd20, 5'd21, 5'd20, 1'b1, 5'd20, 1'b0, 5'd21, 1'b1, 4'h0});
    #0.5;
    check("R8 same-cycle update", 2'd1, 2'd3);

    // R6: register zero with every stage writing zero, fresh data pattern.
    @(posedge clk);
    set_data(32'hFFFF_FFFF);
    apply({5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 4'h0});
    @(negedge clk);
    check("R6 zero source", 2'd0, 2'd0);

    // R5: destination off by one bit in every stage.
    @(posedge clk);
    apply({5'd16, 5'd1, 5'd17, 1'b1, 5'd0, 1'b1, 5'd24, 1'b1, 4'h0});
    @(negedge clk);
    check("R5 near miss", 2'd0, 2'd0);

    // R3 then R2: enable execute on top of memory and write-back matches.
    @(posedge clk);
    apply({5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b1, 5'd9, 1'b1, 4'h0});
    @(negedge clk);
    check("R3 mem over wb", 2'd2, 2'd2);
    @(posedge clk);
    ex_we = 1'b1;
    @(negedge clk);
    check("R2 ex over all", 2'd1, 2'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule